// File: doc/BRIEF.md
# Rectangle Blit and Fill Engine

The engine runs one rectangle operation per start pulse. It latches its whole control bundle when it accepts the pulse, checks the pixel format, the raster op and the geometry, and then either copies a source rectangle onto a destination rectangle or paints the destination with a solid colour. All pixel traffic goes through a single word-wide memory port that carries one word per handshake. The port addresses 32-bit words, while every offset and pitch on the control side is given in bytes.

Either edge of a rectangle can be the anchor. A coordinate may name the near corner, and then the rectangle grows right and down from it. It may instead name the far corner, and then the rectangle extends left or up from it. A copy whose source and destination share a pitch behaves as if the whole source were read before the first destination word is written, so overlapping rectangles stay intact. When the operation completes, the engine pulses done, or it pulses error if a check failed. On success it also presents the destination coordinates a follow-on operation would use.

Top module: `blit_engine`

## Requirements
- R1: `pix_fmt[3:0]` selects the bytes per pixel: code 2 gives 1, codes 3 and 4 give 2, code 5 gives 3, code 6 gives 4. Every other code ends the operation with an error pulse and no memory write.
- R2: When `fwd_x` is 0, the start X is the programmed X plus 1 minus `rect_w`, computed modulo 2^16. When `fwd_x` is 1, the start X is the programmed X. `fwd_y` applies the same rule to Y and `rect_h`. For a copy, the source coordinates use the same rule with the destination width and height.
- R3: When `sel_own` is 1, the destination uses `dst_pitch`/`dst_base` and the source uses `src_pitch`/`src_base`. When `sel_own` is 0, both use `def_pitch`/`def_base`. All pitches and bases are in bytes.
- R4: A destination pitch of zero, or a source pitch of zero in a copy, ends the operation with an error pulse and no memory write.
- R5: A start X or start Y above 0x3FFF, a base at or beyond the end of memory, or a rectangle whose last byte (base + (sy+h-1)*pitch + (sx+w)*bpp - 1) is at or beyond the end of memory ends the operation with an error pulse and no memory write.
- R6: `rop` 0xCC copies the source. 0xF0 fills with `brush_color`. 0x00 fills with 0xFF000000. 0xFF fills with 0xFFFFFFFF. Any other code ends with an error pulse and no memory write.
- R7: After a successful copy, `nxt_x` is the start X plus `rect_w` if `fwd_x`=1, else the start X. `nxt_y` follows the same rule with the start Y and `rect_h`.
- R8: After a successful fill, `nxt_y` follows the rule of R7, and `nxt_x` equals the programmed destination X.
- R9: A copy between rectangles that share a pitch gives the same memory contents as if the whole source were read before any destination write, for every direction setting.
- R10: `start` is taken only while `busy` is 0. `done` and `error` each last exactly one cycle, and `busy` stays high from the cycle after acceptance through that pulse.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. A transfer completes in a cycle with both high, and a read takes `mem_rdata` in that cycle.
- R12: Each row touches ceil(`rect_w`*bpp/4) words, starting at word (base + row_y*pitch + sx*bpp) div 4. A width or height of zero writes nothing but still gives a done pulse and the R7/R8 coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start one operation (taken when idle) |
| pix_fmt | input | 4 | Pixel format code |
| fwd_x | input | 1 | 1: left-to-right, 0: X is the right edge |
| fwd_y | input | 1 | 1: top-to-bottom, 0: Y is the bottom edge |
| rop | input | 8 | Raster op code |
| sel_own | input | 1 | 1: per-surface pitch/base, 0: shared defaults |
| src_x | input | 16 | Source X |
| src_y | input | 16 | Source Y |
| dst_x | input | 16 | Destination X |
| dst_y | input | 16 | Destination Y |
| rect_w | input | 14 | Width in pixels |
| rect_h | input | 14 | Height in rows |
| src_pitch | input | 16 | Source pitch in bytes |
| dst_pitch | input | 16 | Destination pitch in bytes |
| def_pitch | input | 16 | Shared pitch in bytes |
| src_base | input | 32 | Source base byte offset |
| dst_base | input | 32 | Destination base byte offset |
| def_base | input | 32 | Shared base byte offset |
| brush_color | input | 32 | Fill colour for pattern copy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle abort pulse |
| nxt_x | output | 16 | Updated destination X |
| nxt_y | output | 16 | Updated destination Y |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or answers the request |

## Verification
The completion pulse and a fresh start request can land in the same cycle. In that cycle `busy` is still high, so the new request must be dropped. The bench provokes this by raising `start` with a different raster op exactly while `done` is high. It then expects `busy` to stay low one cycle later, no second done or error pulse, and the memory image unchanged from the first operation's expected result. A second pairing comes from the random `mem_ready` stalls: the last write of a rectangle can be held off, and the done pulse must still come only after the write has landed.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int COORD_W = 16;
    localparam int DIM_W   = 14;
    localparam int PITCH_W = 16;
    localparam int OFF_W   = 32;
    localparam int WORD_W  = 32;
    localparam int CALC_W  = 48;
    localparam int COL_W   = DIM_W + 1;

    localparam logic [7:0] ROP_COPY  = 8'hCC;
    localparam logic [7:0] ROP_PAT   = 8'hF0;
    localparam logic [7:0] ROP_BLACK = 8'h00;
    localparam logic [7:0] ROP_WHITE = 8'hFF;

    localparam logic [COORD_W-1:0] COORD_MAX = 16'h3FFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_DONE, ST_FAIL
    } st_e;

    typedef struct packed {
        logic [3:0]         fmt;
        logic               fwd_x;
        logic               fwd_y;
        logic [7:0]         rop;
        logic               own;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic [DIM_W-1:0]   w;
        logic [DIM_W-1:0]   h;
        logic [PITCH_W-1:0] sp;
        logic [PITCH_W-1:0] dp;
        logic [PITCH_W-1:0] defp;
        logic [OFF_W-1:0]   so;
        logic [OFF_W-1:0]   doff;
        logic [OFF_W-1:0]   defo;
        logic [WORD_W-1:0]  brush;
    } cfg_t;

    typedef struct packed {
        st_e                st;
        cfg_t               cfg;
        logic [CALC_W-1:0]  src_row;
        logic [CALC_W-1:0]  dst_row;
        logic [COL_W-1:0]   col;
        logic [DIM_W-1:0]   row;
        logic [WORD_W-1:0]  rdbuf;
        logic               desc;
        logic [COORD_W-1:0] nx;
        logic [COORD_W-1:0] ny;
    } eng_t;
endpackage

// File: rtl/blit_pix_fmt.sv
module blit_pix_fmt (
    input  logic [3:0] code,
    output logic [2:0] bytes,
    output logic       ok
);
    always_comb begin
        case (code)
            4'd2:       bytes = 3'd1;
            4'd3, 4'd4: bytes = 3'd2;
            4'd5:       bytes = 3'd3;
            4'd6:       bytes = 3'd4;
            default:    bytes = 3'd0;
        endcase
        ok = (bytes != 3'd0);
    end
endmodule

// File: rtl/blit_rect_geom.sv
module blit_rect_geom
    import blit_pkg::*;
#(
    parameter int MEM_BYTES = 16384
) (
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [DIM_W-1:0]   w,
    input  logic [DIM_W-1:0]   h,
    input  logic               fwd_x,
    input  logic               fwd_y,
    input  logic [2:0]         bytes,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [OFF_W-1:0]   base,
    output logic [COORD_W-1:0] start_x,
    output logic [COORD_W-1:0] start_y,
    output logic [CALC_W-1:0]  first_byte,
    output logic [CALC_W-1:0]  last_row_byte,
    output logic               bad
);
    localparam logic [CALC_W-1:0] END_BYTE = CALC_W'(MEM_BYTES);

    logic [CALC_W-1:0] row_span;
    logic [CALC_W-1:0] end_byte;
    logic              empty;

    always_comb begin
        start_x = fwd_x ? pos_x : pos_x + COORD_W'(1) - COORD_W'(w);
        start_y = fwd_y ? pos_y : pos_y + COORD_W'(1) - COORD_W'(h);
        empty   = (w == '0) || (h == '0);
        first_byte = CALC_W'(base)
                   + CALC_W'(start_y) * CALC_W'(pitch)
                   + CALC_W'(start_x) * CALC_W'(bytes);
        last_row_byte = empty ? first_byte
                      : first_byte + CALC_W'(h - DIM_W'(1)) * CALC_W'(pitch);
        row_span = CALC_W'(w) * CALC_W'(bytes);
        end_byte = last_row_byte + row_span - CALC_W'(1);
        bad = (pitch == '0)
            || (start_x > COORD_MAX) || (start_y > COORD_MAX)
            || (CALC_W'(base) >= END_BYTE)
            || (!empty && (end_byte >= END_BYTE));
    end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter  int MEM_WORDS = 4096,
    localparam int AW        = $clog2(MEM_WORDS),
    localparam int MEM_BYTES = MEM_WORDS * 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         pix_fmt,
    input  logic               fwd_x,
    input  logic               fwd_y,
    input  logic [7:0]         rop,
    input  logic               sel_own,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [DIM_W-1:0]   rect_w,
    input  logic [DIM_W-1:0]   rect_h,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [PITCH_W-1:0] def_pitch,
    input  logic [OFF_W-1:0]   src_base,
    input  logic [OFF_W-1:0]   dst_base,
    input  logic [OFF_W-1:0]   def_base,
    input  logic [WORD_W-1:0]  brush_color,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic [COORD_W-1:0] nxt_x,
    output logic [COORD_W-1:0] nxt_y,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ready
);
    eng_t q, d;

    logic [2:0]         bytes;
    logic               fmt_ok;
    logic [PITCH_W-1:0] d_pitch, s_pitch;
    logic [OFF_W-1:0]   d_base, s_base;
    logic [COORD_W-1:0] d_sx, d_sy, s_sx, s_sy;
    logic [CALC_W-1:0]  d_first, d_last, s_first, s_last;
    logic               d_bad, s_bad;
    logic               is_copy, op_known, empty, last_col, last_row;
    logic [DIM_W+2:0]   span;
    logic [COL_W-1:0]   wpr, cidx;
    logic [CALC_W-1:0]  row_word;
    logic [WORD_W-1:0]  fill_color;

    assign d_pitch = q.cfg.own ? q.cfg.dp   : q.cfg.defp;
    assign s_pitch = q.cfg.own ? q.cfg.sp   : q.cfg.defp;
    assign d_base  = q.cfg.own ? q.cfg.doff : q.cfg.defo;
    assign s_base  = q.cfg.own ? q.cfg.so   : q.cfg.defo;

    blit_pix_fmt u_fmt (
        .code  (q.cfg.fmt),
        .bytes (bytes),
        .ok    (fmt_ok)
    );

    blit_rect_geom #(.MEM_BYTES(MEM_BYTES)) u_dst_geom (
        .pos_x (q.cfg.dx), .pos_y (q.cfg.dy),
        .w (q.cfg.w), .h (q.cfg.h),
        .fwd_x (q.cfg.fwd_x), .fwd_y (q.cfg.fwd_y),
        .bytes (bytes), .pitch (d_pitch), .base (d_base),
        .start_x (d_sx), .start_y (d_sy),
        .first_byte (d_first), .last_row_byte (d_last), .bad (d_bad)
    );

    blit_rect_geom #(.MEM_BYTES(MEM_BYTES)) u_src_geom (
        .pos_x (q.cfg.sx), .pos_y (q.cfg.sy),
        .w (q.cfg.w), .h (q.cfg.h),
        .fwd_x (q.cfg.fwd_x), .fwd_y (q.cfg.fwd_y),
        .bytes (bytes), .pitch (s_pitch), .base (s_base),
        .start_x (s_sx), .start_y (s_sy),
        .first_byte (s_first), .last_row_byte (s_last), .bad (s_bad)
    );

    always_comb begin
        is_copy  = (q.cfg.rop == ROP_COPY);
        op_known = is_copy || (q.cfg.rop == ROP_PAT)
                || (q.cfg.rop == ROP_BLACK) || (q.cfg.rop == ROP_WHITE);
        case (q.cfg.rop)
            ROP_PAT:   fill_color = q.cfg.brush;
            ROP_BLACK: fill_color = 32'hFF00_0000;
            default:   fill_color = 32'hFFFF_FFFF;
        endcase
        empty    = (q.cfg.w == '0) || (q.cfg.h == '0);
        span     = (DIM_W+3)'(q.cfg.w) * (DIM_W+3)'(bytes);
        wpr      = COL_W'((span + (DIM_W+3)'(3)) >> 2);
        last_col = (q.col == wpr - COL_W'(1));
        last_row = (q.row == q.cfg.h - DIM_W'(1));
        cidx     = q.desc ? (wpr - COL_W'(1) - q.col) : q.col;
        row_word = ((q.st == ST_READ) ? q.src_row : q.dst_row) >> 2;
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cfg = '{fmt: pix_fmt, fwd_x: fwd_x, fwd_y: fwd_y, rop: rop,
                              own: sel_own, sx: src_x, sy: src_y, dx: dst_x,
                              dy: dst_y, w: rect_w, h: rect_h, sp: src_pitch,
                              dp: dst_pitch, defp: def_pitch, so: src_base,
                              doff: dst_base, defo: def_base, brush: brush_color};
                    d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!fmt_ok || !op_known || d_bad || (is_copy && s_bad)) begin
                    d.st = ST_FAIL;
                end else begin
                    d.ny   = q.cfg.fwd_y ? d_sy + COORD_W'(q.cfg.h) : d_sy;
                    d.nx   = !is_copy ? q.cfg.dx
                           : (q.cfg.fwd_x ? d_sx + COORD_W'(q.cfg.w) : d_sx);
                    d.desc = is_copy && (d_first > s_first);
                    d.dst_row = d.desc ? d_last : d_first;
                    d.src_row = d.desc ? s_last : s_first;
                    d.row  = '0;
                    d.col  = '0;
                    d.st   = empty ? ST_DONE : (is_copy ? ST_READ : ST_WRITE);
                end
            end
            ST_READ: begin
                if (mem_ready) begin
                    d.rdbuf = mem_rdata;
                    d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    d.st = is_copy ? ST_READ : ST_WRITE;
                    if (!last_col) begin
                        d.col = q.col + COL_W'(1);
                    end else if (last_row) begin
                        d.st = ST_DONE;
                    end else begin
                        d.col = '0;
                        d.row = q.row + DIM_W'(1);
                        d.dst_row = q.desc ? q.dst_row - CALC_W'(d_pitch)
                                           : q.dst_row + CALC_W'(d_pitch);
                        d.src_row = q.desc ? q.src_row - CALC_W'(s_pitch)
                                           : q.src_row + CALC_W'(s_pitch);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign error     = (q.st == ST_FAIL);
    assign nxt_x     = q.nx;
    assign nxt_y     = q.ny;
    assign mem_req   = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we    = (q.st == ST_WRITE);
    assign mem_addr  = AW'(row_word + CALC_W'(cidx));
    assign mem_wdata = is_copy ? q.rdbuf : fill_color;

    assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !(done || error));

    assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_fail_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (!busy && !mem_req));

    assert_req_in_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done && !error));
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb;
    localparam int MW = 4096;
    localparam int MB = MW * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start = 1'b0;
    logic [3:0]  t_fmt = 4'd6;
    logic        t_fx = 1'b1, t_fy = 1'b1, t_own = 1'b0;
    logic [7:0]  t_rop = 8'hCC;
    logic [15:0] t_sx = 0, t_sy = 0, t_dx = 0, t_dy = 0;
    logic [13:0] t_w = 0, t_h = 0;
    logic [15:0] t_sp = 256, t_dp = 256, t_defp = 256;
    logic [31:0] t_so = 0, t_do = 0, t_defo = 0, t_brush = 0;

    logic        busy, done, error, mem_req, mem_we;
    logic        mem_ready = 1'b0;
    logic [15:0] nxt_x, nxt_y;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] mem  [0:MW-1];
    logic [31:0] expm [0:MW-1];
    logic [31:0] snap [0:MW-1];

    int total = 0;
    int bad = 0;
    int cyc = 0;

    blit_engine #(.MEM_WORDS(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_fmt(t_fmt),
        .fwd_x(t_fx), .fwd_y(t_fy), .rop(t_rop), .sel_own(t_own),
        .src_x(t_sx), .src_y(t_sy), .dst_x(t_dx), .dst_y(t_dy),
        .rect_w(t_w), .rect_h(t_h), .src_pitch(t_sp), .dst_pitch(t_dp),
        .def_pitch(t_defp), .src_base(t_so), .dst_base(t_do),
        .def_base(t_defo), .brush_color(t_brush), .busy(busy), .done(done),
        .error(error), .nxt_x(nxt_x), .nxt_y(nxt_y), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_req && mem_we && mem_ready) mem[mem_addr] <= mem_wdata;
    always @(negedge clk) mem_ready <= (($urandom % 4) != 0);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int bpp_of(input logic [3:0] c);
        case (c)
            4'd2: return 1;
            4'd3, 4'd4: return 2;
            4'd5: return 3;
            4'd6: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic geom(input logic [15:0] x, input logic [15:0] y, input int b,
                        input longint p, input longint o, output bit gbad,
                        output logic [15:0] gx, output logic [15:0] gy, output longint first);
        longint lastb;
        gx = t_fx ? x : 16'(x + 16'd1 - 16'(t_w));
        gy = t_fy ? y : 16'(y + 16'd1 - 16'(t_h));
        first = o + longint'(gy) * p + longint'(gx) * b;
        lastb = first + (longint'(t_h) - 1) * p + longint'(t_w) * b - 1;
        gbad = (p == 0) || (gx > 16'h3FFF) || (gy > 16'h3FFF) || (o >= MB)
            || (t_w != 0 && t_h != 0 && lastb >= MB);
    endtask

    task automatic model(output bit eerr, output logic [15:0] ex, output logic [15:0] ey);
        int b;
        bit cp, dbad, sbad;
        logic [15:0] dsx, dsy, ssx, ssy;
        longint dp, sp, dof, sof, dfirst, sfirst, wpr;
        logic [31:0] col;
        b = bpp_of(t_fmt);
        cp = (t_rop == 8'hCC);
        dp = t_own ? t_dp : t_defp;  sp = t_own ? t_sp : t_defp;
        dof = t_own ? t_do : t_defo; sof = t_own ? t_so : t_defo;
        for (int i = 0; i < MW; i++) begin
            expm[i] = mem[i];
            snap[i] = mem[i];
        end
        geom(t_dx, t_dy, b, dp, dof, dbad, dsx, dsy, dfirst);
        geom(t_sx, t_sy, b, sp, sof, sbad, ssx, ssy, sfirst);
        eerr = (b == 0) || !(cp || t_rop == 8'hF0 || t_rop == 8'h00 || t_rop == 8'hFF)
            || dbad || (cp && sbad);
        ex = cp ? (t_fx ? 16'(dsx + 16'(t_w)) : dsx) : t_dx;
        ey = t_fy ? 16'(dsy + 16'(t_h)) : dsy;
        if (eerr) return;
        col = (t_rop == 8'hF0) ? t_brush : (t_rop == 8'h00) ? 32'hFF000000 : 32'hFFFFFFFF;
        wpr = (longint'(t_w) * b + 3) / 4;
        for (int r = 0; r < int'(t_h); r++)
            for (int c = 0; c < int'(wpr); c++)
                expm[((dfirst + r * dp) >> 2) + c] =
                    cp ? snap[((sfirst + r * sp) >> 2) + c] : col;
    endtask

    task automatic run_op(input string tag, input bit collide);
        bit eerr;
        logic [15:0] ex, ey;
        int wait_cnt;
        int badw;
        model(eerr, ex, ey);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cnt = 0;
        while (!(done || error) && wait_cnt < 20000) begin
            @(negedge clk);
            wait_cnt++;
        end
        check(wait_cnt < 20000, {tag, " R10 completion"}, wait_cnt, 20000);
        check(error == eerr && done == !eerr, {tag, " status R1 R4 R5 R6"}, {done, error}, {!eerr, eerr});
        if (collide) begin
            t_rop = 8'hF0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(!busy, {tag, " start during done ignored R10"}, busy, 0);
            @(negedge clk);
            check(!done && !error, {tag, " no second pulse R10"}, {done, error}, 0);
            t_rop = 8'hCC;
        end else begin
            @(negedge clk);
            check(!done && !error, {tag, " single pulse R10"}, {done, error}, 0);
        end
        if (!eerr) begin
            check(nxt_x == ex, {tag, " nxt_x R7 R8"}, nxt_x, ex);
            check(nxt_y == ey, {tag, " nxt_y R7 R8"}, nxt_y, ey);
        end
        badw = -1;
        for (int i = 0; i < MW; i++) if (mem[i] !== expm[i] && badw < 0) badw = i;
        if (badw < 0) check(1'b1, {tag, " memory R2 R3 R9 R12"}, 0, 0);
        else check(1'b0, {tag, " memory R2 R3 R9 R12"}, mem[badw], expm[badw]);
    endtask

    task automatic setup(input logic [3:0] f, input logic [7:0] r, input bit fx, input bit fy,
                         input bit own, input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h);
        t_fmt = f; t_rop = r; t_fx = fx; t_fy = fy; t_own = own;
        t_sx = 16'(sx); t_sy = 16'(sy); t_dx = 16'(dx); t_dy = 16'(dy);
        t_w = 14'(w); t_h = 14'(h);
        t_sp = 256; t_dp = 256; t_defp = 256;
        t_so = 0; t_do = 8192; t_defo = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < MW; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        check(!busy && !done && !error && !mem_req, "reset state R10", {busy, done, error, mem_req}, 0);
        check(nxt_x == 0 && nxt_y == 0, "reset coords R7", {nxt_x, nxt_y}, 0);
        rst_n = 1'b1;
        t_brush = 32'h1234_5678;

        // R1 R6 R7: plain copy, own surfaces
        setup(6, 8'hCC, 1, 1, 1, 3, 2, 5, 4, 6, 3);          run_op("copy fwd", 0);
        // R2 R7: far-corner anchored copy
        setup(6, 8'hCC, 0, 0, 1, 10, 9, 12, 8, 4, 3);        run_op("copy rev R2", 0);
        // R8 R6: fills with each colour source
        setup(6, 8'hF0, 1, 0, 0, 0, 0, 7, 9, 5, 4);          run_op("fill brush R8", 0);
        setup(6, 8'h00, 0, 1, 0, 0, 0, 20, 3, 3, 2);         run_op("fill black R6", 0);
        setup(6, 8'hFF, 1, 1, 1, 0, 0, 2, 2, 2, 2);          run_op("fill white R6", 0);
        // R9: overlapping copies on the shared surface
        setup(6, 8'hCC, 1, 1, 0, 10, 5, 12, 6, 8, 4);        run_op("overlap down R9", 0);
        setup(6, 8'hCC, 0, 0, 0, 14, 9, 12, 8, 8, 4);        run_op("overlap up R9", 0);
        setup(6, 8'hCC, 0, 1, 0, 9, 4, 11, 4, 6, 3);         run_op("overlap right R9", 0);
        // R12: sub-word formats
        setup(3, 8'hF0, 1, 1, 0, 0, 0, 3, 2, 5, 2);          run_op("fill 16bpp R12", 0);
        setup(5, 8'hCC, 1, 1, 1, 1, 1, 1, 3, 3, 2);          run_op("copy 24bpp R12", 0);
        setup(2, 8'hFF, 1, 1, 0, 0, 0, 5, 1, 7, 1);          run_op("fill 8bpp R12", 0);
        setup(6, 8'hF0, 1, 1, 0, 0, 0, 4, 4, 0, 3);          run_op("empty R12", 0);
        // R1 R6 R4 R5: aborts
        setup(7, 8'hCC, 1, 1, 1, 0, 0, 0, 0, 2, 2);          run_op("bad fmt R1", 0);
        setup(6, 8'h55, 1, 1, 1, 0, 0, 0, 0, 2, 2);          run_op("bad rop R6", 0);
        setup(6, 8'hF0, 1, 1, 1, 0, 0, 0, 0, 2, 2); t_dp = 0; run_op("zero dst pitch R4", 0);
        setup(6, 8'hCC, 1, 1, 1, 0, 0, 0, 0, 2, 2); t_sp = 0; run_op("zero src pitch R4", 0);
        setup(6, 8'hF0, 1, 1, 0, 0, 0, 16'h4000, 0, 1, 1);   run_op("coord limit R5", 0);
        setup(6, 8'hF0, 0, 1, 0, 0, 0, 2, 0, 4, 1);          run_op("coord wrap R5", 0);
        setup(6, 8'hF0, 1, 1, 0, 0, 0, 0, 63, 64, 2);        run_op("past end R5", 0);
        setup(6, 8'hF0, 1, 1, 0, 0, 0, 0, 62, 64, 2);        run_op("exact fit R5", 0);
        setup(6, 8'hF0, 1, 1, 1, 0, 0, 0, 0, 1, 1); t_do = MB; run_op("base past end R5", 0);
        // R3: shared defaults ignore per-surface values
        setup(6, 8'hCC, 1, 1, 0, 2, 2, 30, 20, 4, 2); t_dp = 0; t_sp = 0; t_defo = 1024;
        run_op("default select R3", 0);
        // R10: start colliding with done
        setup(6, 8'hCC, 1, 1, 1, 1, 1, 8, 8, 3, 2);          run_op("collide R10", 1);

        for (int n = 0; n < 40; n++) begin
            int w, h;
            logic [7:0] rp;
            w = 1 + int'($urandom % 12);
            h = 1 + int'($urandom % 6);
            case ($urandom % 5)
                0: rp = 8'hF0; 1: rp = 8'h00; 2: rp = 8'hFF;
                default: rp = 8'hCC;
            endcase
            if ($urandom % 10 == 0) rp = 8'h55;
            setup(($urandom % 4 == 0) ? 4'd3 : 4'd6, rp, 1'($urandom), 1'($urandom),
                  1'($urandom), w - 1 + int'($urandom % 20), h - 1 + int'($urandom % 10),
                  w - 1 + int'($urandom % 20), h - 1 + int'($urandom % 10), w, h);
            t_brush = $urandom;
            if (t_own && ($urandom % 2 == 0)) t_sp = 512;
            run_op($sformatf("random %0d", n), n % 9 == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule